// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves one 8-bit voice sample per frame across a PCM serial highway in both directions. The highway is timed by a bit clock and a frame sync. The block watches both signals from a faster system clock. It finds the frame start, counts a programmable number of bit clocks, and then opens an 8-bit time slot. During the slot it shifts a transmit byte out MSB first and collects a receive byte from the incoming line. Outside the slot the transmit driver is released, which is modelled by a deasserted output enable.

Three configuration fields shape the slot:
- **Start offset**: the slot starts 0 to 7 bit clocks after the frame start.
- **Edge code**: a 2-bit code picks the bit-clock edge that launches transmit bits and, independently, the edge that samples receive bits.
- **Bit length**: each bit lasts one bit-clock period in single mode or two periods in double mode.

The block captures all three fields at the frame start, so a change made in the middle of a frame never disturbs the slot in progress. The received byte comes back on the parallel side together with a one-cycle valid strobe.

The controller is a three-state machine:
- **IDLE**: goes to **WAIT** on a frame start. All other inputs are ignored.
- **WAIT**: counts launch edges down from the captured offset. When the count is zero, the next launch edge moves it to **SHIFT**, loads the transmit byte and enables the driver.
- **SHIFT**: each launch edge either ends the first half of a double-length bit or closes a bit. The launch edge that closes the eighth bit returns it to **IDLE** and releases the driver. A frame start that arrives in WAIT or SHIFT is ignored.

The system clock must run at least four times faster than the bit clock. The bit clock, frame sync and receive line all pass through synchronizers of the same depth, so each received bit stays aligned with the clock edge on which it is sampled.

Top module: `pcm_slot_port`

## Requirements
- R1: The frame sync is sampled on each bit-clock falling edge. A frame start is a falling edge on which the frame sync is high after being low at the previous falling edge. With offset code N (3 bits, 0 to 7), the first slot bit is launched on the (N+1)-th launch edge after that falling edge.
- R2: A frame start seen while a slot is pending (WAIT) or active (SHIFT) is ignored. The current slot completes unchanged, and no further slot opens until the next frame start seen in IDLE.
- R3: Edge code bit 1 selects the launch edge: 0 means rising, 1 means falling. Edge code bit 0 selects the receive sample edge: 0 means falling, 1 means rising. The four codes are therefore 00 = launch rise / sample fall, 01 = rise / rise, 10 = fall / fall and 11 = fall / rise.
- R4: When the double bit is 1, each data bit is held for two launch-edge intervals. When it is 0, each bit lasts one interval.
- R5: If the launch and sample edges differ, receive data is sampled on the sample edge inside the bit; in double mode, that is the sample edge in the bit's second period. If the two edges are the same, receive data is sampled on the launch edge that closes the bit.
- R6: The transmit byte is captured on the slot's first launch edge and is sent MSB first.
- R7: The transmit output enable is high for exactly 8 bit times, from the slot's first launch edge to the launch edge that ends the eighth bit. The serial output is 0 whenever the enable is low.
- R8: The first received bit lands in bit 7 of the received byte. The received byte updates in the same cycle as a one-cycle valid pulse, issued once per slot after the eighth sample. It holds its value between pulses.
- R9: The offset, edge code and double bit are captured at the frame start. Changes to them, or to the transmit byte, after the slot's first launch edge have no effect on the current slot.
- R10: After reset the output enable, serial output, valid strobe and received byte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Highway bit clock (asynchronous) |
| fs | input | 1 | Frame sync (asynchronous) |
| cfg_offset | input | 3 | Slot start offset in bit clocks |
| cfg_double | input | 1 | 1 = each bit spans two bit-clock periods |
| cfg_edge | input | 2 | Launch/sample edge code (see R3) |
| tx_byte | input | 8 | Sample to transmit in the next slot |
| dr | input | 1 | Serial receive line |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit driver enable |
| rx_byte | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |

## Verification
The bench drives the bit clock and frame sync itself and predicts, edge by edge, which launch edge opens and closes the slot. It uses offsets 0, 3 and 7, all four edge codes, and both bit lengths. A controller with an off-by-one offset count, or one that counts from the wrong edge, shows up as a slot shifted by one edge. In same-edge modes the receive byte must be taken on the closing edge. A design that sampled on the launch edge that opens each bit would return the byte shifted by one bit, with the line's idle value in it. In double mode, sampling in the first half of each bit, or forgetting to hold the bit, breaks both directions. Two further scenarios change the configuration and the transmit byte in the middle of a slot, and raise the frame sync a second time inside the slot. A design that re-captured its configuration on the fly or restarted on the second sync would corrupt the byte or open a second slot.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    localparam int SLOT_BITS_DEF = 8;
    localparam int OFS_W         = 3;
    localparam int ECODE_W       = 2;

    typedef struct packed {
        logic [OFS_W-1:0]   offset;
        logic               dbl;
        logic [ECODE_W-1:0] ecode;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } slot_state_t;

    // Edge code bit 1: launch on falling edge when set.
    function automatic logic launch_on_fall(input logic [ECODE_W-1:0] c);
        return c[1];
    endfunction

    // Edge code bit 0: sample on rising edge when set.
    function automatic logic sample_on_rise(input logic [ECODE_W-1:0] c);
        return c[0];
    endfunction

    // Launch and sample share one edge for codes 01 and 10.
    function automatic logic same_edge(input logic [ECODE_W-1:0] c);
        return c[1] ^ c[0];
    endfunction

endpackage

// File: rtl/pcm_line_sync.sv
module pcm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fs_in,
    input  logic dr_in,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic dr_s,
    output logic frame_start
);

    localparam int LINES = 3;

    logic [LINES-1:0] pipe [STAGES];
    logic             bclk_q;
    logic             fs_at_fall;
    logic             bclk_s;
    logic             fs_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= {bclk_in, fs_in, dr_in};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        bclk_s = pipe[STAGES-1][2];
        fs_s   = pipe[STAGES-1][1];
        dr_s   = pipe[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q     <= 1'b0;
            fs_at_fall <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
            if (bclk_fall) fs_at_fall <= fs_s;
        end
    end

    always_comb begin
        bclk_rise   = bclk_s & ~bclk_q;
        bclk_fall   = ~bclk_s & bclk_q;
        frame_start = bclk_fall & fs_s & ~fs_at_fall;
    end

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_BITS = SLOT_BITS_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bclk_rise,
    input  logic      bclk_fall,
    input  logic      frame_start,
    input  slot_cfg_t cfg_in,
    output logic      launch_evt,
    output logic      load_tx,
    output logic      shift_tx,
    output logic      sample_stb,
    output logic      last_stb,
    output logic      slot_oe
);

    localparam int CNT_W = $clog2(SLOT_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_BITS - 1);

    slot_state_t      state_q, state_d;
    slot_cfg_t        cfg_q;
    logic [OFS_W-1:0] skip_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             phase_q;
    logic             samp_edge;
    logic             bit_end;
    logic             at_last;

    always_comb begin
        launch_evt = launch_on_fall(cfg_q.ecode) ? bclk_fall : bclk_rise;
        samp_edge  = sample_on_rise(cfg_q.ecode) ? bclk_rise : bclk_fall;
        bit_end    = !cfg_q.dbl || phase_q;
        at_last    = (bit_cnt_q == LAST_BIT);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_start)                          state_d = ST_WAIT;
            ST_WAIT:  if (launch_evt && skip_q == '0)           state_d = ST_SHIFT;
            ST_SHIFT: if (launch_evt && bit_end && at_last)     state_d = ST_IDLE;
            default:                                            state_d = ST_IDLE;
        endcase
    end

    // Counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            skip_q    <= '0;
            bit_cnt_q <= '0;
            phase_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && frame_start) begin
                cfg_q  <= cfg_in;
                skip_q <= cfg_in.offset;
            end
            if (state_q == ST_WAIT && launch_evt) begin
                if (skip_q != '0) begin
                    skip_q <= skip_q - 1'b1;
                end else begin
                    bit_cnt_q <= '0;
                    phase_q   <= 1'b0;
                end
            end
            if (state_q == ST_SHIFT && launch_evt) begin
                if (!bit_end) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q   <= 1'b0;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        load_tx    = (state_q == ST_WAIT) && launch_evt && (skip_q == '0);
        shift_tx   = (state_q == ST_SHIFT) && launch_evt && bit_end && !at_last;
        sample_stb = (state_q == ST_SHIFT) && bit_end &&
                     (same_edge(cfg_q.ecode) ? launch_evt : samp_edge);
        last_stb   = sample_stb && at_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_oe <= 1'b0;
        else        slot_oe <= (state_d == ST_SHIFT);
    end

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             enable,
    input  logic [WIDTH-1:0] din,
    output logic             dout
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= din;
        else if (shift) sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end

    assign dout = enable & sr_q[WIDTH-1];

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             last,
    input  logic             din,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sample) sr_q <= {sr_q[WIDTH-2:0], din};
            if (last) begin
                dout  <= {sr_q[WIDTH-2:0], din};
                valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_BITS   = SLOT_BITS_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fs,
    input  logic [OFS_W-1:0]     cfg_offset,
    input  logic                 cfg_double,
    input  logic [ECODE_W-1:0]   cfg_edge,
    input  logic [SLOT_BITS-1:0] tx_byte,
    input  logic                 dr,
    output logic                 dx,
    output logic                 dx_oe,
    output logic [SLOT_BITS-1:0] rx_byte,
    output logic                 rx_valid
);

    slot_cfg_t cfg_in;
    logic      bclk_rise, bclk_fall, dr_s, frame_start;
    logic      launch_evt, load_tx, shift_tx, sample_stb, last_stb;

    always_comb begin
        cfg_in.offset = cfg_offset;
        cfg_in.dbl    = cfg_double;
        cfg_in.ecode  = cfg_edge;
    end

    pcm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_in     (bclk),
        .fs_in       (fs),
        .dr_in       (dr),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .dr_s        (dr_s),
        .frame_start (frame_start)
    );

    pcm_slot_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start),
        .cfg_in      (cfg_in),
        .launch_evt  (launch_evt),
        .load_tx     (load_tx),
        .shift_tx    (shift_tx),
        .sample_stb  (sample_stb),
        .last_stb    (last_stb),
        .slot_oe     (dx_oe)
    );

    pcm_tx_shift #(.WIDTH(SLOT_BITS)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_tx),
        .shift  (shift_tx),
        .enable (dx_oe),
        .din    (tx_byte),
        .dout   (dx)
    );

    pcm_rx_shift #(.WIDTH(SLOT_BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample_stb),
        .last   (last_stb),
        .din    (dr_s),
        .dout   (rx_byte),
        .valid  (rx_valid)
    );

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
    parameter int SLOT_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dx,
    input logic                 dx_oe,
    input logic                 rx_valid,
    input logic [SLOT_BITS-1:0] rx_byte,
    input logic                 launch_evt,
    input logic                 frame_start
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8

    AST_RX_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte)); // R8

    AST_OE_RISE_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx_oe) |-> $past(launch_evt)); // R1

    AST_OE_FALL_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dx_oe) |-> $past(launch_evt)); // R7

    AST_DX_MOVES_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_oe && $past(dx_oe) && !$stable(dx)) |-> $past(launch_evt)); // R3

    AST_NO_OE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !dx_oe) |=> !dx_oe); // R1

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dx          (dx),
    .dx_oe       (dx_oe),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .launch_evt  (launch_evt),
    .frame_start (frame_start)
);

// File: tb/pcm_slot_port_tb_top.sv
module pcm_slot_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fs = 1'b0;
    logic [2:0] cfg_offset = '0;
    logic       cfg_double = 1'b0;
    logic [1:0] cfg_edge = '0;
    logic [7:0] tx_byte = '0;
    logic       dr = 1'b0;
    logic       dx, dx_oe, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    logic [7:0] rx_got = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcm_slot_port dut_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs(fs),
        .cfg_offset(cfg_offset), .cfg_double(cfg_double), .cfg_edge(cfg_edge),
        .tx_byte(tx_byte), .dr(dr), .dx(dx), .dx_oe(dx_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            rx_got = rx_byte;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One frame: 8 system clocks per bit-clock edge; even edge index = rising.
    task automatic run_frame(input string tag, input logic [2:0] ofs, input bit dbl,
                             input logic [1:0] ec, input logic [7:0] txb,
                             input logic [7:0] rxb, input bit mid_cfg, input bit mid_fs);
        int m = dbl ? 2 : 1;
        int last_e = 2 * (int'(ofs) + 1 + 8 * m) + 7;
        int n, nl, k;
        bit exp_oe, exp_dx;
        bit dx_ok = 1;
        cfg_offset = ofs; cfg_double = dbl; cfg_edge = ec; tx_byte = txb;
        vcount = 0;
        for (int e = 0; e <= last_e; e++) begin
            @(negedge clk);
            bclk = (e % 2 == 0);
            repeat (4) @(negedge clk);
            if (e == 0) fs = 1'b1;
            if (e == 2) fs = 1'b0;
            if (mid_fs && e == 2 * int'(ofs) + 6) fs = 1'b1;
            if (mid_fs && e == 2 * int'(ofs) + 8) fs = 1'b0;
            if (mid_cfg && e == 2 * int'(ofs) + 5) begin
                cfg_offset = ~ofs; cfg_double = ~dbl; cfg_edge = ~ec; tx_byte = ~txb;
            end
            if (ec[1]) n = (e % 2 == 1) ? (e - 1) / 2 : -1;
            else       n = (e % 2 == 0) ? e / 2 : -1;
            if (n >= int'(ofs) + 1 && n <= int'(ofs) + 8 * m && ((n - int'(ofs) - 1) % m == 0))
                dr = rxb[7 - (n - int'(ofs) - 1) / m];
            repeat (2) @(negedge clk);
            if (ec[1]) nl = (e >= 1) ? (e - 1) / 2 : 0;
            else       nl = e / 2;
            exp_oe = (nl >= int'(ofs) + 1) && (nl <= int'(ofs) + 8 * m);
            k = (nl - int'(ofs) - 1) / m;
            exp_dx = exp_oe ? txb[7 - k] : 1'b0;
            check(dx_oe == exp_oe, {tag, " R7"}, $sformatf("enable after edge %0d", e),
                  32'(dx_oe), 32'(exp_oe));
            if (dx !== exp_dx) dx_ok = 0;
            check(dx == exp_dx, {tag, " R6"}, $sformatf("data after edge %0d", e),
                  32'(dx), 32'(exp_dx));
            @(negedge clk);
        end
        check(vcount == 1, {tag, " R8"}, "valid pulse count", 32'(vcount), 32'd1);
        check(rx_got == rxb, {tag, " R8"}, "received byte", 32'(rx_got), 32'(rxb));
        check(dx_ok, tag, "whole transmit slot", 32'(dx_ok), 32'd1);
    endtask

    task automatic test_reset();
        check(dx_oe == 1'b0,    "R10", "enable at reset", 32'(dx_oe), 0);
        check(dx == 1'b0,       "R10", "data at reset", 32'(dx), 0);
        check(rx_valid == 1'b0, "R10", "valid at reset", 32'(rx_valid), 0);
        check(rx_byte == 8'h00, "R10", "rx byte at reset", 32'(rx_byte), 0);
    endtask

    task automatic test_default();
        run_frame("R1", 3'd0, 0, 2'b00, 8'hA5, 8'h3C, 0, 0);
    endtask

    task automatic test_offsets();
        run_frame("R1", 3'd3, 0, 2'b00, 8'h96, 8'hE1, 0, 0);
        run_frame("R1", 3'd7, 0, 2'b00, 8'h01, 8'h80, 0, 0);
    endtask

    task automatic test_edges();
        run_frame("R3", 3'd0, 0, 2'b01, 8'hC3, 8'h5A, 0, 0);
        run_frame("R5", 3'd2, 0, 2'b10, 8'h69, 8'hB4, 0, 0);
        run_frame("R3", 3'd1, 0, 2'b11, 8'h7E, 8'h81, 0, 0);
    endtask

    task automatic test_double();
        run_frame("R4", 3'd0, 1, 2'b00, 8'hD2, 8'h4B, 0, 0);
        run_frame("R5", 3'd4, 1, 2'b01, 8'h35, 8'hCA, 0, 0);
        run_frame("R4", 3'd1, 1, 2'b11, 8'h8F, 8'h71, 0, 0);
    endtask

    task automatic test_cfg_hold();
        run_frame("R9", 3'd2, 0, 2'b00, 8'h5C, 8'h93, 1, 0);
        run_frame("R9", 3'd5, 1, 2'b10, 8'hE7, 8'h18, 1, 0);
    endtask

    task automatic test_fs_ignored();
        run_frame("R2", 3'd1, 0, 2'b00, 8'hB1, 8'h4E, 0, 1);
        run_frame("R2", 3'd0, 1, 2'b01, 8'h2D, 8'hD4, 0, 1);
    endtask

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        test_reset();
        test_default();
        test_offsets();
        test_edges();
        test_double();
        test_cfg_hold();
        test_fs_ignored();
        finished = 1;
        print_summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements actual=running expected=done");
            print_summary();
            $finish;
        end
    end

endmodule